// File: doc/BRIEF.md
# Memory Mapping Register Unit

This block holds the page-mapping registers of a memory-expansion scheme. There are four banks of 32 registers: a system bank, a user bank, and two banks that serve DMA ports A and B. Each register supplies a 10-bit physical page number. With mapping on, the active bank (system or user) turns a 15-bit logical word address into a 20-bit physical address. With mapping off, the logical address passes through zero-extended. The block also holds a mapping-enable bit, a bank-select bit, a fence value and a sticky violation flag.

A CPU microsequencer drives the block through a one-cycle command strobe. The command carries an operand word, a count, a register pointer and a memory pointer. Some commands move one register per clock between the banks and an external word memory. That memory's read data returns in the same cycle as the address. These commands can load or store a whole bank, copy a system or user bank into a port bank, or transfer a run of registers through one flat 128-entry index. The linear transfer stops at 16-register boundaries when an interrupt is pending, and software then reissues it with the returned pointers. Protection rules refuse map loads and state changes while protected mode is on.

Top module: `map_reg_unit`

## Requirements
- R1: After reset, mapping is off, the system bank is selected, the fence is 0, the unit is idle and the violation flag is clear. With mapping off, `phys_addr_o` equals `log_addr_i` zero-extended to 20 bits.
- R2: With mapping on, the unit builds the physical address from two parts. The register is picked by the five upper logical bits in the active bank (user when `user_sel_o`=1, otherwise system). The result is that register's low 10 bits above the low 10 logical bits.
- R3: A whole-bank command (op 0) with operand bit 15 set writes registers 0..31 of bank `cmd_map_i` (0 system, 1 user, 2 port A, 3 port B) to memory words operand[14:0]+i. This direction raises no violation, even in protected mode.
- R4: A whole-bank command with operand bit 15 clear loads the 32 registers from memory words operand[14:0]+i. In both directions `opnd_o` becomes operand+32.
- R5: While `prot_i` is high, any command that would load a map register sets `viol_o` and changes no register. These are a whole-bank load, a copy, a linear load and a register-only load.
- R6: A state-set or fence command with `prot_i` high sets `viol_o` and changes nothing, but only while the user bank is selected. With the system bank selected it executes normally.
- R7: The copy command (op 1) copies all 32 registers. The source is the user bank if operand bit 15 is 1, otherwise the system bank. The destination is port B if operand bit 0 is 1, otherwise port A.
- R8: The linear transfer (op 2) indexes registers as bank*32+register through the 7-bit `regp`. A negative count stores registers to memory at `mptr` and counts up. A positive count loads from memory and counts down. Both pointers advance by one per register, and the unit finishes with `done_o` when the count reaches zero.
- R9: A linear transfer in progress stops when `irq_i` is high and the updated count has its low four bits all ones. It then pulses `resume_o` instead of `done_o` and leaves the current count and pointers on `cnt_o`, `regp_o` and `mptr_o`.
- R10: The state-set command (op 4) sets mapping enable from operand bit 15 and the bank select from bit 14 (1 means user). It pulses `intr_dis_o` with `done_o`.
- R11: A linear transfer or register-only load with a zero count only reports done. The register-only load (op 3) also does nothing when its count is negative. With a positive count it writes the memory-pointer value into successive registers.
- R12: The fence command (op 5) loads `fence_o` from operand bits 14..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_i | input | 1 | Protected mode active |
| irq_i | input | 1 | Interrupt pending |
| cmd_valid_i | input | 1 | Command strobe, taken when idle |
| cmd_op_i | input | 3 | Command code |
| cmd_map_i | input | 2 | Bank for whole-bank transfer |
| opnd_i | input | 16 | Operand word |
| cnt_i | input | 16 | Signed transfer count |
| regp_i | input | 7 | Linear register pointer |
| mptr_i | input | 16 | Memory pointer / register-only data |
| log_addr_i | input | 15 | Logical word address |
| phys_addr_o | output | 20 | Translated physical address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, same cycle |
| busy_o | output | 1 | Multi-cycle command running |
| done_o | output | 1 | Command finished (pulse) |
| resume_o | output | 1 | Linear transfer suspended (pulse) |
| viol_o | output | 1 | Last command refused |
| intr_dis_o | output | 1 | Interrupt-disable request (pulse) |
| map_en_o | output | 1 | Mapping enabled |
| user_sel_o | output | 1 | User bank selected |
| fence_o | output | 15 | Fence value |
| opnd_o | output | 16 | Advanced operand |
| cnt_o | output | 16 | Remaining count |
| regp_o | output | 7 | Updated register pointer |
| mptr_o | output | 16 | Updated memory pointer |

## Verification
A bad register write shows up on `phys_addr_o` as soon as a logical address selects that page. A wrong bank index shows up in memory words written by a later store command, which is how the port banks are inspected. A wrong pointer or count update appears on `cnt_o`, `regp_o` and `mptr_o` in the cycle the completion or suspension pulse is seen. A wrong violation decision shows up the cycle after the strobe as a wrong `viol_o`, or as a register or state bit that changed when it should not have.

// File: rtl/mru_pkg.sv
package mru_pkg;
  typedef enum logic [2:0] {
    CMD_MAPX  = 3'd0,
    CMD_COPY  = 3'd1,
    CMD_LIN   = 3'd2,
    CMD_REGS  = 3'd3,
    CMD_STATE = 3'd4,
    CMD_FENCE = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {S_IDLE, S_MAP, S_LIN} seq_st_e;
endpackage

// File: rtl/mru_regfile.sv
module mru_regfile #(
  parameter int unsigned DW    = 16,
  parameter int unsigned N     = 128,
  parameter int unsigned AW    = 7,
  parameter int unsigned PPN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [AW-1:0]    xaddr_i,
  output logic [PPN_W-1:0] xdata_o
);
  logic [DW-1:0] regs [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we_i) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = regs[raddr_i];
  assign xdata_o = regs[xaddr_i][PPN_W-1:0];
endmodule

// File: rtl/mru_xlate.sv
module mru_xlate #(
  parameter int unsigned LA_W  = 15,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned PPN_W = 10,
  parameter int unsigned RI_W  = 7,
  localparam int unsigned PG_W = LA_W - OFF_W,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input  logic             en_i,
  input  logic             user_i,
  input  logic [LA_W-1:0]  la_i,
  output logic [RI_W-1:0]  xaddr_o,
  input  logic [PPN_W-1:0] ppn_i,
  output logic [PA_W-1:0]  pa_o
);
  // active bank is system (0) or user (1)
  assign xaddr_o = {1'b0, user_i, la_i[LA_W-1:OFF_W]};

  generate
    if (PA_W > LA_W) begin : g_wide
      always_comb pa_o = en_i ? {ppn_i, la_i[OFF_W-1:0]}
                              : {{(PA_W-LA_W){1'b0}}, la_i};
    end else begin : g_narrow
      always_comb pa_o = en_i ? {ppn_i, la_i[OFF_W-1:0]} : la_i[PA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mru_seq.sv
module mru_seq
  import mru_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned LA_W = 15,
  parameter int unsigned PG_W = 5,
  localparam int unsigned RI_W = PG_W + 2,
  localparam int unsigned NPM  = 1 << PG_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prot_i,
  input  logic            irq_i,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [1:0]      cmd_map_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic [DW-1:0]   cnt_i,
  input  logic [RI_W-1:0] regp_i,
  input  logic [DW-1:0]   mptr_i,
  output logic            rf_we_o,
  output logic [RI_W-1:0] rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic [RI_W-1:0] rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            mem_we_o,
  output logic [LA_W-1:0] mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            resume_o,
  output logic            viol_o,
  output logic            intr_dis_o,
  output logic            map_en_o,
  output logic            user_sel_o,
  output logic [LA_W-1:0] fence_o,
  output logic [DW-1:0]   opnd_o,
  output logic [DW-1:0]   cnt_o,
  output logic [RI_W-1:0] regp_o,
  output logic [DW-1:0]   mptr_o
);
  seq_st_e         st_q;
  cmd_e            op_q;
  logic [1:0]      map_q, src_q, dst_q;
  logic            store_q;
  logic [PG_W-1:0] idx_q;
  logic [LA_W-1:0] base_q;
  logic [DW-1:0]   cnt_nx;
  logic            is_load, viol_c;
  cmd_e            op_in;

  assign op_in   = cmd_e'(cmd_op_i);
  assign is_load = (op_in == CMD_MAPX && !opnd_i[DW-1]) || (op_in == CMD_COPY) ||
                   ((op_in == CMD_LIN || op_in == CMD_REGS) && !cnt_i[DW-1] && (|cnt_i));
  assign viol_c  = prot_i && (is_load ||
                   ((op_in == CMD_STATE || op_in == CMD_FENCE) && user_sel_o));
  assign cnt_nx  = store_q ? cnt_o + DW'(1) : cnt_o - DW'(1);
  assign busy_o  = (st_q != S_IDLE);

  always_comb begin
    rf_we_o     = 1'b0;
    rf_waddr_o  = '0;
    rf_wdata_o  = '0;
    rf_raddr_o  = '0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      S_MAP: begin
        mem_addr_o = base_q + {{(LA_W-PG_W){1'b0}}, idx_q};
        if (op_q == CMD_COPY) begin
          rf_raddr_o = {src_q, idx_q};
          rf_waddr_o = {dst_q, idx_q};
          rf_wdata_o = rf_rdata_i;
          rf_we_o    = 1'b1;
        end else if (store_q) begin
          rf_raddr_o  = {map_q, idx_q};
          mem_we_o    = 1'b1;
          mem_wdata_o = rf_rdata_i;
        end else begin
          rf_waddr_o = {map_q, idx_q};
          rf_wdata_o = mem_rdata_i;
          rf_we_o    = 1'b1;
        end
      end
      S_LIN: begin
        rf_raddr_o = regp_o;
        rf_waddr_o = regp_o;
        mem_addr_o = mptr_o[LA_W-1:0];
        if (op_q == CMD_REGS) begin
          rf_we_o    = 1'b1;
          rf_wdata_o = mptr_o;
        end else if (store_q) begin
          mem_we_o    = 1'b1;
          mem_wdata_o = rf_rdata_i;
        end else begin
          rf_we_o    = 1'b1;
          rf_wdata_o = mem_rdata_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  op_q <= CMD_MAPX;
      map_q <= '0;  src_q <= '0;  dst_q <= '0;
      store_q <= 1'b0;  idx_q <= '0;  base_q <= '0;
      done_o <= 1'b0;  resume_o <= 1'b0;  viol_o <= 1'b0;  intr_dis_o <= 1'b0;
      map_en_o <= 1'b0;  user_sel_o <= 1'b0;  fence_o <= '0;
      opnd_o <= '0;  cnt_o <= '0;  regp_o <= '0;  mptr_o <= '0;
    end else begin
      done_o     <= 1'b0;
      resume_o   <= 1'b0;
      intr_dis_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (cmd_valid_i) begin
          op_q   <= op_in;
          viol_o <= viol_c;
          if (viol_c) begin
            done_o <= 1'b1;
          end else begin
            unique case (op_in)
              CMD_MAPX: begin
                map_q   <= cmd_map_i;
                store_q <= opnd_i[DW-1];
                base_q  <= opnd_i[LA_W-1:0];
                opnd_o  <= opnd_i + DW'(NPM);
                idx_q   <= '0;
                st_q    <= S_MAP;
              end
              CMD_COPY: begin
                src_q <= {1'b0, opnd_i[DW-1]};
                dst_q <= {1'b1, opnd_i[0]};
                idx_q <= '0;
                st_q  <= S_MAP;
              end
              CMD_LIN, CMD_REGS: begin
                cnt_o   <= cnt_i;
                regp_o  <= regp_i;
                mptr_o  <= mptr_i;
                store_q <= (op_in == CMD_LIN) && cnt_i[DW-1];
                if (cnt_i == '0 || (op_in == CMD_REGS && cnt_i[DW-1])) done_o <= 1'b1;
                else st_q <= S_LIN;
              end
              CMD_STATE: begin
                map_en_o   <= opnd_i[DW-1];
                user_sel_o <= opnd_i[DW-2];
                intr_dis_o <= 1'b1;
                done_o     <= 1'b1;
              end
              CMD_FENCE: begin
                fence_o <= opnd_i[LA_W-1:0];
                done_o  <= 1'b1;
              end
              default: done_o <= 1'b1;
            endcase
          end
        end
        S_MAP: begin
          idx_q <= idx_q + PG_W'(1);
          if (idx_q == '1) begin
            st_q   <= S_IDLE;
            done_o <= 1'b1;
          end
        end
        S_LIN: begin
          cnt_o  <= cnt_nx;
          regp_o <= regp_o + RI_W'(1);
          mptr_o <= mptr_o + DW'(1);
          if (cnt_nx == '0) begin
            st_q   <= S_IDLE;
            done_o <= 1'b1;
          end else if (irq_i && cnt_nx[3:0] == 4'hF) begin
            st_q     <= S_IDLE;
            resume_o <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/map_reg_unit.sv
module map_reg_unit #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LA_W  = 15,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned PPN_W = 10,
  localparam int unsigned PG_W = LA_W - OFF_W,
  localparam int unsigned RI_W = PG_W + 2,
  localparam int unsigned NREG = 1 << RI_W,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prot_i,
  input  logic            irq_i,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [1:0]      cmd_map_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic [DW-1:0]   cnt_i,
  input  logic [RI_W-1:0] regp_i,
  input  logic [DW-1:0]   mptr_i,
  input  logic [LA_W-1:0] log_addr_i,
  output logic [PA_W-1:0] phys_addr_o,
  output logic            mem_we_o,
  output logic [LA_W-1:0] mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            resume_o,
  output logic            viol_o,
  output logic            intr_dis_o,
  output logic            map_en_o,
  output logic            user_sel_o,
  output logic [LA_W-1:0] fence_o,
  output logic [DW-1:0]   opnd_o,
  output logic [DW-1:0]   cnt_o,
  output logic [RI_W-1:0] regp_o,
  output logic [DW-1:0]   mptr_o
);
  logic             rf_we;
  logic [RI_W-1:0]  rf_waddr, rf_raddr, rf_xaddr;
  logic [DW-1:0]    rf_wdata, rf_rdata;
  logic [PPN_W-1:0] rf_ppn;

  mru_regfile #(.DW(DW), .N(NREG), .AW(RI_W), .PPN_W(PPN_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .raddr_i(rf_raddr), .rdata_o(rf_rdata),
    .xaddr_i(rf_xaddr), .xdata_o(rf_ppn)
  );

  mru_xlate #(.LA_W(LA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .RI_W(RI_W)) u_xl (
    .en_i(map_en_o), .user_i(user_sel_o), .la_i(log_addr_i),
    .xaddr_o(rf_xaddr), .ppn_i(rf_ppn), .pa_o(phys_addr_o)
  );

  mru_seq #(.DW(DW), .LA_W(LA_W), .PG_W(PG_W)) u_seq (
    .clk_i, .rst_ni, .prot_i, .irq_i,
    .cmd_valid_i, .cmd_op_i, .cmd_map_i, .opnd_i, .cnt_i, .regp_i, .mptr_i,
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .busy_o, .done_o, .resume_o, .viol_o, .intr_dis_o,
    .map_en_o, .user_sel_o, .fence_o, .opnd_o, .cnt_o, .regp_o, .mptr_o
  );
endmodule

// File: rtl/mru_chk.sv
module mru_chk #(
  parameter int unsigned DW   = 16,
  parameter int unsigned LA_W = 15,
  parameter int unsigned PA_W = 20
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            prot_i,
  input logic            cmd_valid_i,
  input logic [2:0]      cmd_op_i,
  input logic [DW-1:0]   cnt_i,
  input logic [LA_W-1:0] log_addr_i,
  input logic [PA_W-1:0] phys_addr_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            resume_o,
  input logic            viol_o,
  input logic            intr_dis_o,
  input logic            map_en_o,
  input logic            user_sel_o,
  input logic [LA_W-1:0] fence_o,
  input logic [DW-1:0]   cnt_o
);
  logic take;
  assign take = cmd_valid_i && !busy_o;

  a_r1_flat_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_o |-> phys_addr_o == PA_W'(log_addr_i));

  a_r9_resume_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (cnt_o[3:0] == 4'hF) && !busy_o);

  a_r8_single_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && resume_o));

  a_r10_intdis_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_dis_o |-> done_o && !viol_o);

  a_r5_copy_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && prot_i && cmd_op_i == 3'd1) |=> viol_o && !busy_o && done_o);

  a_r6_fence_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && prot_i && user_sel_o && cmd_op_i == 3'd5) |=> viol_o && $stable(fence_o));

  a_r11_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == 3'd2 && cnt_i == '0) |=> done_o && !busy_o);
endmodule

bind map_reg_unit mru_chk #(.DW(DW), .LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prot_i(prot_i), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .cnt_i(cnt_i), .log_addr_i(log_addr_i),
  .phys_addr_o(phys_addr_o), .busy_o(busy_o), .done_o(done_o),
  .resume_o(resume_o), .viol_o(viol_o), .intr_dis_o(intr_dis_o),
  .map_en_o(map_en_o), .user_sel_o(user_sel_o), .fence_o(fence_o), .cnt_o(cnt_o)
);

// File: tb/map_reg_unit_test.sv
`timescale 1ns/1ps
module map_reg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot = 1'b0, irq = 1'b0, cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_map = '0;
  logic [15:0] opnd = '0, cnt = '0, mptr = '0;
  logic [6:0]  regp = '0;
  logic [14:0] la = '0;
  logic [19:0] pa;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, done, resume, viol, intdis, map_en, user_sel;
  logic [14:0] fence;
  logic [15:0] opnd_r, cnt_r, mptr_r;
  logic [6:0]  regp_r;

  int n_chk = 0, n_bad = 0, cycles = 0, wr_cnt = 0;
  logic saw_done, saw_resume, saw_intdis;
  logic [15:0] bmem [512];

  always #2.5 clk = ~clk;

  map_reg_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .prot_i(prot), .irq_i(irq),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_map_i(cmd_map),
    .opnd_i(opnd), .cnt_i(cnt), .regp_i(regp), .mptr_i(mptr),
    .log_addr_i(la), .phys_addr_o(pa),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .resume_o(resume), .viol_o(viol),
    .intr_dis_o(intdis), .map_en_o(map_en), .user_sel_o(user_sel),
    .fence_o(fence), .opnd_o(opnd_r), .cnt_o(cnt_r), .regp_o(regp_r), .mptr_o(mptr_r)
  );

  assign mem_rdata = bmem[mem_addr[8:0]];
  always @(posedge clk) if (mem_we) begin
    bmem[mem_addr[8:0]] <= mem_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [1:0] mp, input logic [15:0] o,
                     input logic [15:0] c, input logic [6:0] rp, input logic [15:0] mp_ptr);
    int k;
    @(negedge clk);
    cmd_op = op; cmd_map = mp; opnd = o; cnt = c; regp = rp; mptr = mp_ptr;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 0;
    while (!(done || resume) && k < 300) begin
      @(negedge clk);
      k++;
    end
    saw_done = done; saw_resume = resume; saw_intdis = intdis;
  endtask

  task automatic set_state(input logic en, input logic usr);
    run(3'd4, 2'd0, {en, usr, 14'h0}, 16'h0, 7'h0, 16'h0);
  endtask

  task automatic xl(input string tag, input logic [14:0] a, input logic [19:0] exp);
    @(negedge clk);
    la = a;
    #1;
    chk(tag, {12'h0, pa}, {12'h0, exp});
  endtask

  // {enable, user, logical, expected physical}
  localparam logic [36:0] VEC [9] = '{
    {1'b0, 1'b0, 15'h0000, 20'h00000},
    {1'b0, 1'b1, 15'h1234, 20'h01234},
    {1'b0, 1'b0, 15'h7FFF, 20'h07FFF},
    {1'b1, 1'b0, 15'h0000, 20'h40000},
    {1'b1, 1'b0, 15'h1234, 20'h41234},
    {1'b1, 1'b0, 15'h7FFF, 20'h47FFF},
    {1'b1, 1'b1, 15'h0000, 20'h80000},
    {1'b1, 1'b1, 15'h1234, 20'h83234},
    {1'b1, 1'b1, 15'h7FFF, 20'h977FF}
  };

  initial begin
    int errs;
    int w0;
    for (int i = 0; i < 512; i++) bmem[i] = 16'h0;
    for (int i = 0; i < 32; i++) begin
      bmem[16'h40 + i] = 16'h100 + 16'(i);
      bmem[16'h80 + i] = 16'h200 + 16'(3 * i);
    end
    la = 15'h5555;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 viol", {31'h0, viol}, 0);
    chk("R1 map_en", {31'h0, map_en}, 0);
    chk("R1 user_sel", {31'h0, user_sel}, 0);
    chk("R1 fence", {17'h0, fence}, 0);
    chk("R1 flat", {12'h0, pa}, 32'h05555);

    // R4 whole-bank loads
    run(3'd0, 2'd0, 16'h0040, 0, 0, 0);
    chk("R4 done sys", {31'h0, saw_done}, 1);
    chk("R4 opnd sys", {16'h0, opnd_r}, 32'h0060);
    run(3'd0, 2'd1, 16'h0080, 0, 0, 0);
    chk("R4 opnd user", {16'h0, opnd_r}, 32'h00A0);

    // R2 translation table
    foreach (VEC[i]) begin
      set_state(VEC[i][36], VEC[i][35]);
      xl($sformatf("R2 vec%0d", i), VEC[i][34:20], VEC[i][19:0]);
    end

    // R3 whole-bank store, protected mode allowed
    prot = 1'b1;
    set_state(1'b1, 1'b0);
    run(3'd0, 2'd1, 16'h80C0, 0, 0, 0);
    errs = 0;
    for (int i = 0; i < 32; i++) if (bmem[16'hC0 + i] !== 16'h200 + 16'(3 * i)) errs++;
    chk("R3 stored words", errs, 0);
    chk("R3 no viol", {31'h0, viol}, 0);
    chk("R3 opnd", {16'h0, opnd_r}, 32'h80E0);
    prot = 1'b0;

    // R7 copy user->B, read back via linear store of index 96..127
    run(3'd1, 2'd0, 16'h8001, 0, 0, 0);
    run(3'd2, 2'd0, 0, 16'hFFE0, 7'd96, 16'h00E0);
    errs = 0;
    for (int i = 0; i < 32; i++) if (bmem[16'hE0 + i] !== 16'h200 + 16'(3 * i)) errs++;
    chk("R7 user->portB", errs, 0);
    chk("R8 store cnt", {16'h0, cnt_r}, 0);
    chk("R8 store regp wrap", {25'h0, regp_r}, 0);
    chk("R8 store mptr", {16'h0, mptr_r}, 32'h0100);
    run(3'd1, 2'd0, 16'h0000, 0, 0, 0);
    run(3'd2, 2'd0, 0, 16'hFFFE, 7'd64, 16'h0010);
    chk("R7 sys->portA r0", {16'h0, bmem[16'h10]}, 32'h100);
    chk("R7 sys->portA r1", {16'h0, bmem[16'h11]}, 32'h101);

    // R8 linear load into user regs 2..4
    bmem[16'h20] = 16'h03AA; bmem[16'h21] = 16'h03BB; bmem[16'h22] = 16'h03CC;
    run(3'd2, 2'd0, 0, 16'd3, 7'd34, 16'h0020);
    chk("R8 load cnt", {16'h0, cnt_r}, 0);
    chk("R8 load regp", {25'h0, regp_r}, 37);
    chk("R8 load mptr", {16'h0, mptr_r}, 32'h23);
    set_state(1'b1, 1'b1);
    xl("R8 loaded page2", 15'h0855, 20'hEA855);

    // R9 interrupt suspension
    irq = 1'b1;
    run(3'd2, 2'd0, 0, 16'hFFD8, 7'd0, 16'h0100);
    chk("R9 resume1", {31'h0, saw_resume}, 1);
    chk("R9 cnt1", {16'h0, cnt_r}, 32'hFFDF);
    chk("R9 regp1", {25'h0, regp_r}, 7);
    chk("R9 mptr1", {16'h0, mptr_r}, 32'h0107);
    run(3'd2, 2'd0, 0, cnt_r, regp_r, mptr_r);
    chk("R9 resume2", {31'h0, saw_resume}, 1);
    chk("R9 cnt2", {16'h0, cnt_r}, 32'hFFEF);
    chk("R9 regp2", {25'h0, regp_r}, 23);
    irq = 1'b0;
    run(3'd2, 2'd0, 0, cnt_r, regp_r, mptr_r);
    chk("R9 finished", {31'h0, saw_done}, 1);
    chk("R9 regp3", {25'h0, regp_r}, 40);
    chk("R9 mptr3", {16'h0, mptr_r}, 32'h0128);
    chk("R9 word31", {16'h0, bmem[16'h11F]}, 32'h011F);
    chk("R9 word39", {16'h0, bmem[16'h127]}, 32'h0215);

    // R11 zero / negative counts, register-only load
    w0 = wr_cnt;
    run(3'd2, 2'd0, 0, 16'h0000, 7'd9, 16'h0030);
    chk("R11 zero done", {31'h0, saw_done}, 1);
    chk("R11 zero no write", wr_cnt - w0, 0);
    chk("R11 zero regp", {25'h0, regp_r}, 9);
    run(3'd3, 2'd0, 0, 16'hFFFE, 7'd5, 16'h1234);
    set_state(1'b1, 1'b0);
    xl("R11 neg regs nop", 15'h1400, 20'h41400);
    run(3'd3, 2'd0, 0, 16'd1, 7'd6, 16'h0155);
    chk("R11 regs mptr", {16'h0, mptr_r}, 32'h0156);
    xl("R11 regs load", 15'h1800, 20'h55400);

    // R5 refused loads in protected mode
    prot = 1'b1;
    set_state(1'b1, 1'b0);
    chk("R6 sys sel allowed", {31'h0, viol}, 0);
    chk("R10 intdis", {31'h0, saw_intdis}, 1);
    run(3'd0, 2'd0, 16'h00C0, 0, 0, 0);
    chk("R5 bank load viol", {31'h0, viol}, 1);
    xl("R5 bank unchanged", 15'h1234, 20'h41234);
    run(3'd2, 2'd0, 0, 16'd1, 7'd4, 16'h0020);
    chk("R5 lin viol", {31'h0, viol}, 1);
    xl("R5 lin unchanged", 15'h1234, 20'h41234);
    run(3'd3, 2'd0, 0, 16'd1, 7'd4, 16'h03FF);
    chk("R5 regs viol", {31'h0, viol}, 1);
    xl("R5 regs unchanged", 15'h1234, 20'h41234);
    run(3'd1, 2'd0, 16'h0000, 0, 0, 0);
    chk("R5 copy viol", {31'h0, viol}, 1);

    // R6 state/fence guard with user bank selected
    set_state(1'b1, 1'b1);
    chk("R6 switch allowed", {30'h0, viol, user_sel}, 32'h1);
    set_state(1'b0, 1'b0);
    chk("R6 state viol", {31'h0, viol}, 1);
    chk("R6 state kept", {30'h0, map_en, user_sel}, 32'h3);
    chk("R10 no intdis on viol", {31'h0, saw_intdis}, 0);
    run(3'd5, 2'd0, 16'h1111, 0, 0, 0);
    chk("R6 fence viol", {31'h0, viol}, 1);
    chk("R6 fence kept", {17'h0, fence}, 0);

    // R12 fence load
    prot = 1'b0;
    run(3'd5, 2'd0, 16'hDA5A, 0, 0, 0);
    chk("R12 fence", {17'h0, fence}, 32'h5A5A);
    chk("R12 no viol", {31'h0, viol}, 0);

    finish_run();
  end
endmodule